// File: doc/BRIEF.md
# Write Leveling Delay Search Controller

This block sequences write-leveling training for a group of data strobe lanes and measures, for each lane, how far the command and clock path runs ahead of the strobe path. The skew is found in two parts. The fine part comes from a tap sweep. At every tap the block sends one leveling strobe and waits for the clock level that the memory sampled and sent back on a data bit. The tap at which that level first changes from low to high is recorded. Leveling feedback repeats every clock period, so it cannot show whole cycles. The whole-cycle part therefore comes from a second search. An external write/read checker performs a real write and read-back at each candidate cycle offset, and the block keeps the first offset whose data comes back intact.

Software or a power-up sequencer pulses `start`. The block then handles lanes 0 to N-1 in turn and drives the tap, cycle offset and lane select toward the delay lines and the checker. When all lanes are finished it pulses `done` for one cycle. Each lane's result is a whole-cycle count plus a fine-tap count. A per-lane fail bit is set when either search comes up empty, and a summary fail flag is valid together with `done`.

The state machine has eight states. IDLE goes to LANE_INIT on start. LANE_INIT clears both searches and goes to LVL_ISSUE. LVL_ISSUE sends one strobe and goes to LVL_WAIT. From LVL_WAIT, a returned sample goes to CHK_ISSUE on an edge, to LANE_NEXT when the taps are used up, and back to LVL_ISSUE otherwise. CHK_ISSUE sends one check request and goes to CHK_WAIT. From CHK_WAIT, a reported result goes to LANE_NEXT on a match or when the offsets are used up, and back to CHK_ISSUE otherwise. LANE_NEXT goes to LANE_INIT for the next lane, or to DONE after the last lane. DONE goes back to IDLE.

Top module: `wl_search_ctrl`

## Requirements
- R1: After `start` is accepted in IDLE, lanes are handled in ascending order. For each lane, `tap_out` starts at 0 and rises by one per step. Exactly one single-cycle `lvl_pulse` is sent per tap, and the next step begins only after `lvl_valid`.
- R2: The fine result is the first tap t ≥ 1 at which the sample returned for tap t-1 was 0 and the sample for tap t is 1. A 1 at tap 0, or a run of leading 1s, is not an edge. The sweep stops at the edge tap.
- R3: If no edge is found up to tap 2^TAP_W-1, the lane is marked failed, its tap and cycle results read 0, and no check request is sent for it.
- R4: After an edge, cycle offsets 0, 1, … up to CYC_MAX (default 5) are tried in ascending order. Each offset gets one single-cycle `chk_req` with `cyc_out` equal to that offset. The search waits for `chk_valid` and stops at the first `chk_match`=1, whose offset becomes the lane's cycle result.
- R5: If no offset up to CYC_MAX matches, the lane is marked failed. Its fine tap is kept and its cycle result reads 0.
- R6: `done` is a one-cycle pulse after the last lane. `fail` equals the OR of all lane fail bits in the same cycle as `done`, and it and all results are held until the next accepted `start`, which clears them.
- R7: `lvl_pulse` and `chk_req` are never high together. `tap_out` stays unchanged from a strobe to its response.
- R8: After reset, `done`, `fail`, `lvl_pulse`, `chk_req` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training of all lanes (accepted in IDLE only) |
| done | output | 1 | One-cycle pulse when all lanes are finished |
| fail | output | 1 | Some lane failed; valid with done, held after it |
| lane_sel | output | LANE_W | Lane currently being trained |
| tap_out | output | TAP_W | Fine strobe delay tap for the selected lane |
| lvl_pulse | output | 1 | Send one leveling strobe at tap_out |
| lvl_valid | input | 1 | Returned sample is valid |
| lvl_sample | input | 1 | Clock level sampled by the memory |
| cyc_out | output | CYC_W | Candidate whole-cycle offset |
| chk_req | output | 1 | Run one write/read-back check at cyc_out |
| chk_valid | input | 1 | Check result is valid |
| chk_match | input | 1 | Read-back data matched the written data |
| res_tap | output | NUM_LANES*TAP_W | Per-lane fine tap result, lane 0 in low bits |
| res_cyc | output | NUM_LANES*CYC_W | Per-lane cycle result, lane 0 in low bits |
| res_fail | output | NUM_LANES | Per-lane fail bit |

## Verification
The bench aims at samples that are already 1 at tap 0, and at a run of leading 1s that ends before the real rising edge. A design that treated any 1 as the edge would report tap 0 or the start of that run. The bench also places the edge on the last tap and the match on the last offset. Off-by-one limits there would report a false failure or step past the range. It includes lanes with no edge and lanes with no matching offset. A design that mishandled these would send check requests for a lane with no fine result, drop the kept tap, or leave `fail` low. A passing run is repeated after a failing one, which exposes a fail flag that is not cleared by `start`.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [2:0] {
        WL_IDLE      = 3'd0,
        WL_LANE_INIT = 3'd1,
        WL_LVL_ISSUE = 3'd2,
        WL_LVL_WAIT  = 3'd3,
        WL_CHK_ISSUE = 3'd4,
        WL_CHK_WAIT  = 3'd5,
        WL_LANE_NEXT = 3'd6,
        WL_DONE      = 3'd7
    } wl_state_e;

endpackage

// File: rtl/wl_fine_scan.sv
module wl_fine_scan #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             sample,
    output logic [TAP_W-1:0] tap,
    output logic             edge_hit,
    output logic             at_max
);

    logic [TAP_W-1:0] tap_q;
    logic             prev_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q  <= '0;
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (clear) begin
            tap_q  <= '0;
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (step) begin
            tap_q  <= tap_q + 1'b1;
            prev_q <= sample;
            seen_q <= 1'b1;
        end
    end

    // A rising edge needs a recorded low sample on the tap just below.
    assign edge_hit = seen_q && !prev_q && sample;
    assign at_max   = (tap_q == {TAP_W{1'b1}});
    assign tap      = tap_q;

endmodule

// File: rtl/wl_cycle_scan.sv
module wl_cycle_scan #(
    parameter int CYC_MAX = 5,
    parameter int CYC_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CYC_W-1:0] cyc,
    output logic             at_max
);

    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (clear) begin
            cyc_q <= '0;
        end else if (step) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign at_max = (cyc_q == CYC_W'(CYC_MAX));
    assign cyc    = cyc_q;

endmodule

// File: rtl/wl_result_bank.sv
module wl_result_bank #(
    parameter int NUM_LANES = 2,
    parameter int TAP_W     = 6,
    parameter int CYC_W     = 3,
    parameter int LANE_W    = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_all,
    input  logic                       wr_en,
    input  logic [LANE_W-1:0]          wr_lane,
    input  logic [TAP_W-1:0]           wr_tap,
    input  logic [CYC_W-1:0]           wr_cyc,
    input  logic                       wr_fail,
    output logic [NUM_LANES*TAP_W-1:0] res_tap,
    output logic [NUM_LANES*CYC_W-1:0] res_cyc,
    output logic [NUM_LANES-1:0]       res_fail,
    output logic                       fail_any
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [TAP_W-1:0] tap_q;
        logic [CYC_W-1:0] cyc_q;
        logic             fail_q;
        logic             sel;

        assign sel = wr_en && (wr_lane == LANE_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tap_q  <= '0;
                cyc_q  <= '0;
                fail_q <= 1'b0;
            end else if (clear_all) begin
                tap_q  <= '0;
                cyc_q  <= '0;
                fail_q <= 1'b0;
            end else if (sel) begin
                tap_q  <= wr_tap;
                cyc_q  <= wr_cyc;
                fail_q <= wr_fail;
            end
        end

        assign res_tap[g*TAP_W +: TAP_W] = tap_q;
        assign res_cyc[g*CYC_W +: CYC_W] = cyc_q;
        assign res_fail[g]               = fail_q;
    end

    assign fail_any = |res_fail;

endmodule

// File: rtl/wl_search_ctrl.sv
module wl_search_ctrl #(
    parameter int NUM_LANES = 2,
    parameter int TAP_W     = 6,
    parameter int CYC_MAX   = 5,
    parameter int CYC_W     = $clog2(CYC_MAX + 1),
    parameter int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    output logic                       done,
    output logic                       fail,
    output logic [LANE_W-1:0]          lane_sel,
    output logic [TAP_W-1:0]           tap_out,
    output logic                       lvl_pulse,
    input  logic                       lvl_valid,
    input  logic                       lvl_sample,
    output logic [CYC_W-1:0]           cyc_out,
    output logic                       chk_req,
    input  logic                       chk_valid,
    input  logic                       chk_match,
    output logic [NUM_LANES*TAP_W-1:0] res_tap,
    output logic [NUM_LANES*CYC_W-1:0] res_cyc,
    output logic [NUM_LANES-1:0]       res_fail
);

    import wl_pkg::*;

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

    wl_state_e st_q, st_d;

    logic [LANE_W-1:0] lane_q;
    logic              fail_q;
    logic              accept_start;
    logic              last_lane;

    logic              fine_clear, fine_step, edge_hit, tap_at_max;
    logic [TAP_W-1:0]  tap_q;
    logic              cyc_clear, cyc_step, cyc_at_max;
    logic [CYC_W-1:0]  cyc_q;

    logic              wr_en, wr_fail;
    logic [TAP_W-1:0]  wr_tap;
    logic [CYC_W-1:0]  wr_cyc;
    logic              fail_any;

    assign accept_start = (st_q == WL_IDLE) && start;
    assign last_lane    = (lane_q == LAST_LANE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WL_IDLE:      if (start) st_d = WL_LANE_INIT;
            WL_LANE_INIT: st_d = WL_LVL_ISSUE;
            WL_LVL_ISSUE: st_d = WL_LVL_WAIT;
            WL_LVL_WAIT: begin
                if (lvl_valid) begin
                    if (edge_hit)        st_d = WL_CHK_ISSUE;
                    else if (tap_at_max) st_d = WL_LANE_NEXT;
                    else                 st_d = WL_LVL_ISSUE;
                end
            end
            WL_CHK_ISSUE: st_d = WL_CHK_WAIT;
            WL_CHK_WAIT: begin
                if (chk_valid) begin
                    if (chk_match || cyc_at_max) st_d = WL_LANE_NEXT;
                    else                         st_d = WL_CHK_ISSUE;
                end
            end
            WL_LANE_NEXT: st_d = last_lane ? WL_DONE : WL_LANE_INIT;
            WL_DONE:      st_d = WL_IDLE;
            default:      st_d = WL_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        lvl_pulse  = 1'b0;
        chk_req    = 1'b0;
        done       = 1'b0;
        fine_clear = 1'b0;
        fine_step  = 1'b0;
        cyc_clear  = 1'b0;
        cyc_step   = 1'b0;
        wr_en      = 1'b0;
        wr_fail    = 1'b0;
        wr_tap     = tap_q;
        wr_cyc     = cyc_q;
        unique case (st_q)
            WL_IDLE: ;
            WL_LANE_INIT: begin
                fine_clear = 1'b1;
                cyc_clear  = 1'b1;
            end
            WL_LVL_ISSUE: lvl_pulse = 1'b1;
            WL_LVL_WAIT: begin
                if (lvl_valid && !edge_hit) begin
                    if (tap_at_max) begin
                        wr_en   = 1'b1;
                        wr_fail = 1'b1;
                        wr_tap  = '0;
                        wr_cyc  = '0;
                    end else begin
                        fine_step = 1'b1;
                    end
                end
            end
            WL_CHK_ISSUE: chk_req = 1'b1;
            WL_CHK_WAIT: begin
                if (chk_valid) begin
                    if (chk_match) begin
                        wr_en = 1'b1;
                    end else if (cyc_at_max) begin
                        wr_en   = 1'b1;
                        wr_fail = 1'b1;
                        wr_cyc  = '0;
                    end else begin
                        cyc_step = 1'b1;
                    end
                end
            end
            WL_LANE_NEXT: ;
            WL_DONE:      done = 1'b1;
            default: ;
        endcase
    end

    // Lane index and summary fail flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            fail_q <= 1'b0;
        end else if (accept_start) begin
            lane_q <= '0;
            fail_q <= 1'b0;
        end else if (st_q == WL_LANE_NEXT) begin
            if (last_lane) begin
                fail_q <= fail_any;
            end else begin
                lane_q <= lane_q + 1'b1;
            end
        end
    end

    wl_fine_scan #(
        .TAP_W (TAP_W)
    ) u_fine (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (fine_clear),
        .step     (fine_step),
        .sample   (lvl_sample),
        .tap      (tap_q),
        .edge_hit (edge_hit),
        .at_max   (tap_at_max)
    );

    wl_cycle_scan #(
        .CYC_MAX (CYC_MAX),
        .CYC_W   (CYC_W)
    ) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cyc_clear),
        .step   (cyc_step),
        .cyc    (cyc_q),
        .at_max (cyc_at_max)
    );

    wl_result_bank #(
        .NUM_LANES (NUM_LANES),
        .TAP_W     (TAP_W),
        .CYC_W     (CYC_W),
        .LANE_W    (LANE_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (accept_start),
        .wr_en     (wr_en),
        .wr_lane   (lane_q),
        .wr_tap    (wr_tap),
        .wr_cyc    (wr_cyc),
        .wr_fail   (wr_fail),
        .res_tap   (res_tap),
        .res_cyc   (res_cyc),
        .res_fail  (res_fail),
        .fail_any  (fail_any)
    );

    assign lane_sel = lane_q;
    assign tap_out  = tap_q;
    assign cyc_out  = cyc_q;
    assign fail     = fail_q;

endmodule

// File: rtl/wl_search_ctrl_chk.sv
module wl_search_ctrl_chk #(
    parameter int TAP_W   = 6,
    parameter int CYC_MAX = 5,
    parameter int CYC_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             fail,
    input logic [TAP_W-1:0] tap_out,
    input logic [CYC_W-1:0] cyc_out,
    input logic             lvl_pulse,
    input logic             chk_req
);

    assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lvl_pulse && chk_req));

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_pulse |=> !lvl_pulse);

    assert_tap_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_pulse |=> $stable(tap_out));

    assert_check_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> !chk_req);

    assert_offset_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |-> (cyc_out <= CYC_W'(CYC_MAX)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done);

endmodule

bind wl_search_ctrl wl_search_ctrl_chk #(
    .TAP_W   (TAP_W),
    .CYC_MAX (CYC_MAX),
    .CYC_W   (CYC_W)
) chk_i (.*);

// File: tb/wl_search_ctrl_tb_top.sv
`timescale 1ns/1ps
module wl_search_ctrl_tb_top;

    localparam int NL   = 2;
    localparam int TW   = 6;
    localparam int CM   = 5;
    localparam int CW   = 3;
    localparam int TMAX = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, fail;
    logic [0:0]    lane_sel;
    logic [TW-1:0] tap_out;
    logic          lvl_pulse;
    logic          lvl_valid = 1'b0;
    logic          lvl_sample = 1'b0;
    logic [CW-1:0] cyc_out;
    logic          chk_req;
    logic          chk_valid = 1'b0;
    logic          chk_match = 1'b0;
    logic [NL*TW-1:0] res_tap;
    logic [NL*CW-1:0] res_cyc;
    logic [NL-1:0]    res_fail;

    always #2.5 clk = ~clk;

    wl_search_ctrl #(.NUM_LANES(NL), .TAP_W(TW), .CYC_MAX(CM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
        .lane_sel(lane_sel), .tap_out(tap_out), .lvl_pulse(lvl_pulse),
        .lvl_valid(lvl_valid), .lvl_sample(lvl_sample), .cyc_out(cyc_out),
        .chk_req(chk_req), .chk_valid(chk_valid), .chk_match(chk_match),
        .res_tap(res_tap), .res_cyc(res_cyc), .res_fail(res_fail)
    );

    typedef struct {
        int tap; int cyc; int lfail; int fine_fail; int npulse; int nchk; int gfail;
    } exp_t;

    exp_t sb_q[$];
    int   pre_m[NL], edg_m[NL], cyc_m[NL];
    int   pcnt[NL], ccnt[NL], taperr[NL], cycerr[NL];
    int   both_err, order_err, last_lane;
    int   n_checks = 0, n_errs = 0;
    bit   done_seen = 0, finished = 0;

    function automatic bit mdl_sample(int l, int t);
        return (t < pre_m[l]) || (t >= edg_m[l]);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: loads the memory/checker model, pushes expected items, starts a run
    task automatic run_case(int p0, int e0, int c0, int p1, int e1, int c1);
        exp_t it[NL];
        int   g;
        pre_m[0] = p0; edg_m[0] = e0; cyc_m[0] = c0;
        pre_m[1] = p1; edg_m[1] = e1; cyc_m[1] = c1;
        for (int l = 0; l < NL; l++) begin
            int hit;
            pcnt[l] = 0; ccnt[l] = 0; taperr[l] = 0; cycerr[l] = 0;
            hit = -1;
            for (int t = 1; t <= TMAX; t++) begin
                if (hit < 0 && !mdl_sample(l, t-1) && mdl_sample(l, t)) hit = t;
            end
            if (hit < 0) begin
                it[l] = '{tap:0, cyc:0, lfail:1, fine_fail:1, npulse:TMAX+1, nchk:0, gfail:0};
            end else if (cyc_m[l] <= CM) begin
                it[l] = '{tap:hit, cyc:cyc_m[l], lfail:0, fine_fail:0, npulse:hit+1,
                          nchk:cyc_m[l]+1, gfail:0};
            end else begin
                it[l] = '{tap:hit, cyc:0, lfail:1, fine_fail:0, npulse:hit+1,
                          nchk:CM+1, gfail:0};
            end
        end
        both_err = 0; order_err = 0; last_lane = 0;
        g = 0;
        for (int l = 0; l < NL; l++) g |= it[l].lfail;
        for (int l = 0; l < NL; l++) begin
            it[l].gfail = g;
            sb_q.push_back(it[l]);
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done_seen) @(negedge clk);
        done_seen = 0;
        repeat (4) @(negedge clk);
        check("R6", "fail held after done", int'(fail), g);
    endtask

    // Leveling responder: returns the modelled sample one cycle after the strobe
    initial begin
        forever begin
            if (!lvl_pulse) @(negedge clk);
            else begin
                int l, t;
                l = int'(lane_sel); t = int'(tap_out);
                @(negedge clk);
                lvl_sample = mdl_sample(l, t);
                lvl_valid  = 1'b1;
                @(negedge clk);
                lvl_valid  = 1'b0;
            end
        end
    end

    // Write/read-back responder: match when the offset equals the lane's true offset
    initial begin
        forever begin
            if (!chk_req) @(negedge clk);
            else begin
                int l, c;
                l = int'(lane_sel); c = int'(cyc_out);
                repeat (2) @(negedge clk);
                chk_match = (c == cyc_m[l]);
                chk_valid = 1'b1;
                @(negedge clk);
                chk_valid = 1'b0;
                chk_match = 1'b0;
            end
        end
    end

    // Monitor: tracks request streams and compares results on done
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (lvl_pulse && chk_req) both_err++;
                if (lvl_pulse || chk_req) begin
                    if (int'(lane_sel) < last_lane) order_err++;
                    last_lane = int'(lane_sel);
                end
                if (lvl_pulse) begin
                    if (int'(tap_out) != pcnt[lane_sel]) taperr[lane_sel]++;
                    pcnt[lane_sel]++;
                end
                if (chk_req) begin
                    if (int'(cyc_out) != ccnt[lane_sel]) cycerr[lane_sel]++;
                    ccnt[lane_sel]++;
                end
                if (done) begin
                    for (int l = 0; l < NL; l++) begin
                        exp_t e;
                        if (sb_q.size() == 0) begin
                            check("R6", "unexpected done", 1, 0);
                        end else begin
                            e = sb_q.pop_front();
                            check("R2", "fine tap", int'(res_tap[l*TW +: TW]), e.tap);
                            check("R4", "cycle offset", int'(res_cyc[l*CW +: CW]), e.cyc);
                            check(e.fine_fail ? "R3" : "R5", "lane fail bit",
                                  int'(res_fail[l]), e.lfail);
                            check("R1", "strobe count", pcnt[l], e.npulse);
                            check("R1", "tap sequence errors", taperr[l], 0);
                            check(e.fine_fail ? "R3" : "R4", "check request count",
                                  ccnt[l], e.nchk);
                            check("R4", "offset sequence errors", cycerr[l], 0);
                            if (l == 0) check("R6", "fail with done", int'(fail), e.gfail);
                        end
                    end
                    check("R7", "strobe and check overlap", both_err, 0);
                    check("R1", "lane order errors", order_err, 0);
                    done_seen = 1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errs++;
            $display("FAIL R1 watchdog: actual no done expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < NL; l++) begin
            pre_m[l] = 0; edg_m[l] = 0; cyc_m[l] = 0;
            pcnt[l] = 0; ccnt[l] = 0; taperr[l] = 0; cycerr[l] = 0;
        end
        both_err = 0; order_err = 0; last_lane = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "done after reset", int'(done), 0);
        check("R8", "fail after reset", int'(fail), 0);
        check("R8", "strobe after reset", int'(lvl_pulse), 0);
        check("R8", "check req after reset", int'(chk_req), 0);
        check("R8", "tap results after reset", int'(res_tap), 0);
        check("R8", "cycle results after reset", int'(res_cyc), 0);
        check("R8", "lane fails after reset", int'(res_fail), 0);

        // Plain edges; lane 1 edge at tap 1 and offset 0
        run_case(0, 10, 3, 0, 1, 0);
        // Leading ones before the real edge; last offset; last tap
        run_case(5, 20, 5, 0, TMAX, 2);
        // All ones (no edge) and no matching offset
        run_case(0, 0, 1, 0, 7, 9);
        // Clean run after a failing one: fail must clear
        run_case(0, 10, 3, 0, 1, 0);
        // No low sample at all; short leading run then edge
        run_case(TMAX + 1, TMAX + 1, 0, 2, 4, 0);

        check("R6", "leftover expected items", sb_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule